// File: doc/BRIEF.md
# Data-Link Transmit Controller

This block drives the transmit side of a framer's data-link channel. Every cycle in which the framer raises `bit_en`, one bit leaves on `tx_bit`. The block runs in one of two modes. In message mode it sends HDLC frames that are opened and closed by 0x7E flags, zero-bit stuffed, and optionally protected by a CRC-16 frame check sequence. In bit-oriented mode it repeats a 16-bit signalling pattern built from a 6-bit code.

Software reaches the block through three write ports. One carries the control bits (mode, FCS enable, idle flags). One carries a buffer select. The third fills two 8-bit-wide message buffers that work as a ping-pong pair. A start pulse with a byte count hands the selected buffer to the controller. The select then moves to the other buffer, so software can fill it while the first one drains. A one-cycle `done` pulse reports that a buffer has been fully shifted out and is free again.

Top module: `dl_tx_ctrl`

## Requirements
- R1: After reset the block is in bit-oriented mode, with idle and FCS enable cleared, the select at buffer 0, `tx_bit` at 1 and `done` at 0. The first octet sent after reset is a flag.
- R2: In bit-oriented mode (control bit 0 = 0) the output repeats the 16-bit word 0, c0..c5, 0, 1×8 in transmit order. Here c is bits [5:0] of byte 0 of the selected buffer, and the upper two bits of that byte are ignored. A new code takes effect at the next word boundary.
- R3: In bit-oriented mode the idle bit (control bit 2) and the FCS bit (control bit 1) have no effect on the output.
- R4: In message mode (control bit 0 = 1) a frame is an opening flag followed by the buffer bytes in index order, each byte sent LSB first, and then a closing flag. When nothing is pending, flags are sent back to back.
- R5: Between the opening and closing flags, a 0 is inserted after every five consecutive 1s. This includes data bits, FCS bits and a run that ends just before the closing flag. Flags are never stuffed.
- R6: With control bit 1 set when the frame starts, the frame carries the ones-complement of a CRC-16. The CRC uses the reflected polynomial 0x8408, is preset to 0xFFFF and covers the data bits. It is sent low byte first, LSB first. With bit 1 clear, no FCS is sent.
- R7: In message mode with the idle bit set, only flags are sent. A pending message waits until idle is cleared. The bit is sampled at frame boundaries.
- R8: A start pulse is accepted only when all of the following hold: the block is in message mode, the selected buffer is free, and the length is 1..DEPTH. An accepted start marks that buffer busy and moves the select to the other buffer. A start that is refused changes nothing.
- R9: A select write naming a busy buffer is refused. A write naming a free buffer is taken. Whenever exactly one buffer is busy, `sel_rdata` shows the free one.
- R10: `done` pulses for one cycle, with `done_buf` naming the buffer, in the cycle the last frame bit (data or FCS) appears on `tx_bit`. That buffer is free from the same edge. A start given in that same cycle for the other buffer is accepted. Frames leave in the order they were launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Advance the output by one bit |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control bits: [0] message mode, [1] FCS enable, [2] idle flags |
| sel_we | input | 1 | Buffer select write strobe |
| sel_wdata | input | 1 | Requested buffer |
| sel_rdata | output | 1 | Current buffer select |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_id | input | 1 | Buffer written |
| buf_addr | input | IDX_W | Byte index written |
| buf_wdata | input | 8 | Byte written |
| msg_start | input | 1 | Launch the selected buffer |
| msg_len | input | LEN_W | Byte count of the launched message |
| tx_bit | output | 1 | Serial data-link output |
| done | output | 1 | One-cycle end-of-message pulse |
| done_buf | output | 1 | Buffer freed by `done` |

## Verification
Two events can fall in the same clock edge. One is the end of a frame, which frees its buffer. The other is a start pulse for the other buffer. The bench holds `bit_en` high from a known flag boundary, works out from its own frame model the exact bit index of the last frame bit, and drives `msg_start` together with that bit's enable. It then judges both events: the first `done` must land on that index and name buffer 0, and the second frame must follow after a single shared flag, be bit-exact with its own FCS, and produce a second `done` naming buffer 1.

// File: rtl/dl_tx_pkg.sv
package dl_tx_pkg;

  localparam logic [7:0] FLAG_OCTET = 8'h7E;

  typedef enum logic [1:0] {
    ST_FLAG = 2'd0,
    ST_DATA = 2'd1,
    ST_FCS  = 2'd2,
    ST_BOS  = 2'd3
  } ser_st_t;

  // One step of the reflected CRC-16 (x^16+x^12+x^5+1) for a single data bit.
  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic b);
    logic fb;
    fb = crc[0] ^ b;
    crc16_step = {1'b0, crc[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
  endfunction

  // Signalling word, bit i is the i-th bit on the line.
  function automatic logic [15:0] bos_word(input logic [5:0] code);
    bos_word = {8'hFF, 1'b0, code, 1'b0};
  endfunction

endpackage

// File: rtl/dl_tx_regs.sv
module dl_tx_regs #(
  parameter int DEPTH = 16,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_we,
  input  logic [2:0]             ctl_wdata,
  input  logic                   sel_we,
  input  logic                   sel_wdata,
  input  logic                   msg_start,
  input  logic [LEN_W-1:0]       msg_len,
  input  logic                   fin,
  input  logic                   fin_buf,
  output logic                   mode_msg,
  output logic                   fcs_en,
  output logic                   idle_req,
  output logic                   sel_q,
  output logic [1:0]             pend,
  output logic                   older,
  output logic [1:0][LEN_W-1:0]  lens
);

  logic       start_ok;
  logic       sel_wr_ok;
  logic [1:0] pend_n;
  logic       sel_n;

  assign start_ok  = msg_start && mode_msg && !pend[sel_q] &&
                     (msg_len != '0) && (msg_len <= LEN_W'(DEPTH));
  assign sel_wr_ok = sel_we && !pend[sel_wdata];

  always_comb begin
    pend_n = pend;
    if (fin)      pend_n[fin_buf] = 1'b0;
    if (start_ok) pend_n[sel_q]   = 1'b1;
    sel_n = sel_q;
    if (start_ok)       sel_n = !sel_q;
    else if (sel_wr_ok) sel_n = sel_wdata;
    if (pend_n[sel_n] && !pend_n[!sel_n]) sel_n = !sel_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_msg <= 1'b0;
      fcs_en   <= 1'b0;
      idle_req <= 1'b0;
      sel_q    <= 1'b0;
      pend     <= 2'b00;
      older    <= 1'b0;
      lens     <= '0;
    end else begin
      if (ctl_we) begin
        mode_msg <= ctl_wdata[0];
        fcs_en   <= ctl_wdata[1];
        idle_req <= ctl_wdata[2];
      end
      if (start_ok) begin
        lens[sel_q] <= msg_len;
        older       <= pend[!sel_q] ? !sel_q : sel_q;
      end
      pend  <= pend_n;
      sel_q <= sel_n;
    end
  end

  a_r9_sel_on_free: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend[sel_q] && !pend[!sel_q]));

  a_r8_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> pend[$past(sel_q)]);

  a_r10_fin_frees: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !pend[$past(fin_buf)]);

endmodule

// File: rtl/dl_tx_bufs.sv
module dl_tx_bufs #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             wr_buf,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             rd_buf,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  input  logic             code_buf,
  output logic [5:0]       code
);

  logic [1:0][DEPTH-1:0][7:0] mem;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (we && (wr_buf == 1'(g))) begin
        mem[g][wr_idx] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_buf][rd_idx];
  assign code    = mem[code_buf][0][5:0];

endmodule

// File: rtl/dl_tx_serial.sv
module dl_tx_serial
  import dl_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_en,
  input  logic                   mode_msg,
  input  logic                   fcs_en,
  input  logic                   idle_req,
  input  logic [1:0]             pend,
  input  logic                   older,
  input  logic [1:0][LEN_W-1:0]  lens,
  input  logic [7:0]             rd_data,
  input  logic [5:0]             code,
  output logic                   rd_buf,
  output logic [IDX_W-1:0]       rd_idx,
  output logic                   tx_bit,
  output logic                   fin,
  output logic                   fin_buf
);

  ser_st_t          st;
  logic [15:0]      sh;
  logic [3:0]       bcnt;
  logic [IDX_W-1:0] idx;
  logic             cur;
  logic             fcs_on;
  logic [15:0]      crc;
  logic [2:0]       ones;
  logic             zone;
  logic             tx_q;

  // Named internal events.
  logic        pick;
  logic        any_pend;
  logic        stuff_ins;
  logic        octet_end;
  logic        last_byte;
  logic [15:0] crc_nx;

  assign pick      = (pend[0] && pend[1]) ? older : pend[1];
  assign any_pend  = |pend;
  assign stuff_ins = zone && (ones == 3'd5);
  assign octet_end = (st == ST_BOS) ? (bcnt == 4'd15) : (bcnt == 4'd7);
  assign last_byte = (LEN_W'(idx) + LEN_W'(1)) == lens[cur];
  assign crc_nx    = crc16_step(crc, sh[0]);
  assign fin       = bit_en && !stuff_ins && octet_end &&
                     (((st == ST_DATA) && last_byte && !fcs_on) ||
                      ((st == ST_FCS) && idx[0]));
  assign fin_buf   = cur;
  assign rd_buf    = (st == ST_DATA) ? cur : pick;
  assign rd_idx    = (st == ST_DATA) ? (idx + IDX_W'(1)) : '0;
  assign tx_bit    = tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_FLAG;
      sh     <= {8'h00, FLAG_OCTET};
      bcnt   <= '0;
      idx    <= '0;
      cur    <= 1'b0;
      fcs_on <= 1'b0;
      crc    <= 16'hFFFF;
      ones   <= '0;
      zone   <= 1'b0;
      tx_q   <= 1'b1;
    end else if (bit_en) begin
      if (stuff_ins) begin
        tx_q <= 1'b0;
        ones <= '0;
      end else begin
        tx_q <= sh[0];
        ones <= sh[0] ? ones + 3'd1 : 3'd0;
        if (st == ST_FLAG) zone <= 1'b0;
        if (st == ST_DATA) crc <= crc_nx;
        if (!octet_end) begin
          sh   <= {1'b0, sh[15:1]};
          bcnt <= bcnt + 4'd1;
        end else begin
          bcnt <= '0;
          unique case (st)
            ST_FLAG: begin
              if (!mode_msg) begin
                st <= ST_BOS;
                sh <= bos_word(code);
              end else if (!idle_req && any_pend) begin
                st     <= ST_DATA;
                cur    <= pick;
                idx    <= '0;
                sh     <= {8'h00, rd_data};
                crc    <= 16'hFFFF;
                fcs_on <= fcs_en;
                zone   <= 1'b1;
                ones   <= '0;
              end else begin
                sh <= {8'h00, FLAG_OCTET};
              end
            end
            ST_DATA: begin
              if (last_byte) begin
                if (fcs_on) begin
                  st  <= ST_FCS;
                  idx <= '0;
                  sh  <= {8'h00, ~crc_nx[7:0]};
                end else begin
                  st <= ST_FLAG;
                  sh <= {8'h00, FLAG_OCTET};
                end
              end else begin
                idx <= idx + IDX_W'(1);
                sh  <= {8'h00, rd_data};
              end
            end
            ST_FCS: begin
              if (idx[0]) begin
                st <= ST_FLAG;
                sh <= {8'h00, FLAG_OCTET};
              end else begin
                idx <= IDX_W'(1);
                sh  <= {8'h00, ~crc[15:8]};
              end
            end
            ST_BOS: begin
              if (mode_msg) begin
                st <= ST_FLAG;
                sh <= {8'h00, FLAG_OCTET};
              end else begin
                sh <= bos_word(code);
              end
            end
            default: st <= ST_FLAG;
          endcase
        end
      end
    end
  end

  a_r5_stuff_holds_octet: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_ins) |=> (!tx_q && $stable(bcnt)));

  a_r4_octet_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_BOS) |-> (bcnt <= 4'd7));

  a_r2_bos_ones_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (st == ST_BOS) && (bcnt >= 4'd8)) |=> tx_q);

  a_r10_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

endmodule

// File: rtl/dl_tx_ctrl.sv
module dl_tx_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_wdata,
  input  logic             sel_we,
  input  logic             sel_wdata,
  output logic             sel_rdata,
  input  logic             buf_we,
  input  logic             buf_id,
  input  logic [IDX_W-1:0] buf_addr,
  input  logic [7:0]       buf_wdata,
  input  logic             msg_start,
  input  logic [LEN_W-1:0] msg_len,
  output logic             tx_bit,
  output logic             done,
  output logic             done_buf
);

  logic                  mode_msg, fcs_en, idle_req, sel_q, older;
  logic [1:0]            pend;
  logic [1:0][LEN_W-1:0] lens;
  logic                  fin, fin_buf;
  logic                  rd_buf;
  logic [IDX_W-1:0]      rd_idx;
  logic [7:0]            rd_data;
  logic [5:0]            code;

  dl_tx_regs #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sel_we(sel_we), .sel_wdata(sel_wdata),
    .msg_start(msg_start), .msg_len(msg_len),
    .fin(fin), .fin_buf(fin_buf),
    .mode_msg(mode_msg), .fcs_en(fcs_en), .idle_req(idle_req),
    .sel_q(sel_q), .pend(pend), .older(older), .lens(lens)
  );

  dl_tx_bufs #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_bufs (
    .clk(clk), .rst_n(rst_n),
    .we(buf_we), .wr_buf(buf_id), .wr_idx(buf_addr), .wr_data(buf_wdata),
    .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_data(rd_data),
    .code_buf(sel_q), .code(code)
  );

  dl_tx_serial #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .mode_msg(mode_msg), .fcs_en(fcs_en), .idle_req(idle_req),
    .pend(pend), .older(older), .lens(lens),
    .rd_data(rd_data), .code(code),
    .rd_buf(rd_buf), .rd_idx(rd_idx),
    .tx_bit(tx_bit), .fin(fin), .fin_buf(fin_buf)
  );

  assign sel_rdata = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      done_buf <= 1'b0;
    end else begin
      done <= fin;
      if (fin) done_buf <= fin_buf;
    end
  end

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/dl_tx_ctrl_test.sv
module dl_tx_ctrl_test;

  localparam int DEPTH = 16;
  localparam int IDX_W = 4;
  localparam int LEN_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_en = 1'b0;
  logic             ctl_we = 1'b0;
  logic [2:0]       ctl_wdata = '0;
  logic             sel_we = 1'b0;
  logic             sel_wdata = 1'b0;
  logic             sel_rdata;
  logic             buf_we = 1'b0;
  logic             buf_id = 1'b0;
  logic [IDX_W-1:0] buf_addr = '0;
  logic [7:0]       buf_wdata = '0;
  logic             msg_start = 1'b0;
  logic [LEN_W-1:0] msg_len = '0;
  logic             tx_bit;
  logic             done;
  logic             done_buf;

  dl_tx_ctrl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_rdata(sel_rdata),
    .buf_we(buf_we), .buf_id(buf_id), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .msg_start(msg_start), .msg_len(msg_len),
    .tx_bit(tx_bit), .done(done), .done_buf(done_buf)
  );

  always #4 clk = ~clk;

  int vecs = 0;
  int errs = 0;

  logic       exp_b [0:2047];
  int         exp_n;
  int         m_ones;
  int         last_raw;
  logic [7:0] frm [0:15];

  int         poke_step = -1;
  int         poke_kind = 0;
  logic       poke_b;
  int         poke_a;
  logic [7:0] poke_d;
  int         poke_len;

  int   done_cnt;
  int   first_done_step, last_done_step;
  logic first_done_id, last_done_id;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    vecs++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Bench CRC: byte-wise loop over the frame buffer.
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, frm[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  task automatic clear_exp(); exp_n = 0; endtask
  task automatic push_raw(input logic b); exp_b[exp_n] = b; exp_n++; endtask
  task automatic push_flag();
    for (int i = 0; i < 8; i++) push_raw(((8'h7E >> i) & 8'h01) != 0);
  endtask
  task automatic push_stf(input logic b);
    last_raw = exp_n;
    push_raw(b);
    m_ones = b ? m_ones + 1 : 0;
    if (m_ones == 5) begin push_raw(1'b0); m_ones = 0; end
  endtask
  task automatic push_frame(input int n, input bit fcs);
    logic [15:0] c;
    m_ones = 0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) push_stf(frm[i][j]);
    if (fcs) begin
      c = ~ref_crc(n);
      for (int j = 0; j < 16; j++) push_stf(c[j]);
    end
  endtask
  task automatic push_bos(input logic [5:0] c);
    push_raw(1'b0);
    for (int j = 0; j < 6; j++) push_raw(c[j]);
    push_raw(1'b0);
    for (int j = 0; j < 8; j++) push_raw(1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; ctl_we = 1'b0; sel_we = 1'b0;
    buf_we = 1'b0; msg_start = 1'b0; poke_step = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    ctl_we = 1'b1; ctl_wdata = v; @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic wr_sel(input logic v);
    sel_we = 1'b1; sel_wdata = v; @(negedge clk); sel_we = 1'b0;
  endtask
  task automatic wr_buf(input logic id, input int a, input logic [7:0] d);
    buf_we = 1'b1; buf_id = id; buf_addr = IDX_W'(a); buf_wdata = d;
    @(negedge clk); buf_we = 1'b0;
  endtask
  task automatic start(input int len);
    msg_start = 1'b1; msg_len = LEN_W'(len); @(negedge clk); msg_start = 1'b0;
  endtask
  task automatic load_frame(input logic id, input int n);
    for (int i = 0; i < n; i++) wr_buf(id, i, frm[i]);
  endtask

  task automatic run(input string req);
    done_cnt = 0;
    for (int k = 0; k < exp_n; k++) begin
      bit_en = 1'b1;
      if (k == poke_step) begin
        if (poke_kind == 1) begin
          buf_we = 1'b1; buf_id = poke_b; buf_addr = IDX_W'(poke_a); buf_wdata = poke_d;
        end else begin
          msg_start = 1'b1; msg_len = LEN_W'(poke_len);
        end
      end
      @(negedge clk);
      buf_we = 1'b0; msg_start = 1'b0;
      if (done) begin
        done_cnt++;
        if (done_cnt == 1) begin first_done_step = k; first_done_id = done_buf; end
        last_done_step = k; last_done_id = done_buf;
      end
      chk(req, 32'(tx_bit), 32'(exp_b[k]));
    end
    bit_en = 1'b0;
    poke_step = -1;
  endtask

  // R1: reset state, then default bit-oriented output with code 0
  task automatic t_reset();
    do_reset();
    chk("R1 tx_bit", 32'(tx_bit), 32'd1);
    chk("R1 sel_rdata", 32'(sel_rdata), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    clear_exp(); push_flag(); push_bos(6'h00); push_bos(6'h00);
    run("R1 default stream");
  endtask

  // R2 code repeat and update at word boundary; R3 idle/FCS inert
  task automatic t_bos();
    do_reset();
    wr_buf(1'b0, 0, 8'hEB);
    wr_ctl(3'b110);
    clear_exp(); push_flag(); push_bos(6'h2B); push_bos(6'h15); push_bos(6'h15);
    poke_step = 12; poke_kind = 1; poke_b = 1'b0; poke_a = 0; poke_d = 8'h15;
    run("R2 R3 bos stream");
  endtask

  // R4 R5 R6: frame with FCS and stuffing inside data
  task automatic t_frame_fcs();
    int lr;
    do_reset();
    wr_ctl(3'b011);
    frm[0] = 8'h12; frm[1] = 8'hFF; frm[2] = 8'hF8; frm[3] = 8'h7E;
    load_frame(1'b0, 4);
    start(4);
    clear_exp(); push_flag(); push_frame(4, 1'b1); lr = last_raw; push_flag(); push_flag();
    run("R4 R5 R6 fcs frame");
    chk("R10 done step", 32'(first_done_step), 32'(lr));
    chk("R10 done id", 32'(first_done_id), 32'd0);
    chk("R10 done count", 32'(done_cnt), 32'd1);
    wr_sel(1'b0);
    chk("R9 free write taken", 32'(sel_rdata), 32'd0);
  endtask

  // R5 tail stuffing before closing flag, R6 no FCS
  task automatic t_frame_nofcs();
    do_reset();
    wr_ctl(3'b001);
    frm[0] = 8'hFF; frm[1] = 8'hF8;
    load_frame(1'b0, 2);
    start(2);
    clear_exp(); push_flag(); push_frame(2, 1'b0); push_flag(); push_flag();
    run("R5 R6 no-fcs frame");
  endtask

  // R7 idle holds the pending frame
  task automatic t_idle();
    do_reset();
    wr_ctl(3'b101);
    frm[0] = 8'hA5; frm[1] = 8'h3C;
    load_frame(1'b0, 2);
    start(2);
    clear_exp(); for (int i = 0; i < 5; i++) push_flag();
    run("R7 idle flags");
    chk("R7 buffer still busy", 32'(sel_rdata), 32'd1);
    wr_ctl(3'b001);
    clear_exp(); push_flag(); push_frame(2, 1'b0); push_flag();
    run("R7 resume");
  endtask

  // R8 R9 ownership rules
  task automatic t_select();
    do_reset();
    wr_ctl(3'b001);
    chk("R8 sel before", 32'(sel_rdata), 32'd0);
    start(3);
    chk("R8 sel moved", 32'(sel_rdata), 32'd1);
    wr_sel(1'b0);
    chk("R9 busy write refused", 32'(sel_rdata), 32'd1);
    start(0);
    chk("R8 zero length refused", 32'(sel_rdata), 32'd1);
    start(17);
    chk("R8 over length refused", 32'(sel_rdata), 32'd1);
    wr_ctl(3'b000);
    start(2);
    wr_ctl(3'b001);
    chk("R8 bos start refused", 32'(sel_rdata), 32'd1);
    start(2);
    chk("R8 both busy", 32'(sel_rdata), 32'd0);
  endtask

  // R10 end of frame and new start on the same edge
  task automatic t_overlap();
    int lr_a, lr_b;
    do_reset();
    wr_ctl(3'b011);
    frm[0] = 8'h81; frm[1] = 8'h42;
    load_frame(1'b0, 2);
    start(2);
    clear_exp(); push_flag(); push_frame(2, 1'b1); lr_a = last_raw; push_flag();
    frm[0] = 8'h5A;
    load_frame(1'b1, 1);
    push_frame(1, 1'b1); lr_b = last_raw; push_flag();
    poke_step = lr_a; poke_kind = 2; poke_len = 1;
    run("R10 back-to-back stream");
    chk("R10 first done step", 32'(first_done_step), 32'(lr_a));
    chk("R10 first done id", 32'(first_done_id), 32'd0);
    chk("R10 second done step", 32'(last_done_step), 32'(lr_b));
    chk("R10 second done id", 32'(last_done_id), 32'd1);
    chk("R10 done count", 32'(done_cnt), 32'd2);
  endtask

  initial begin
    t_reset();
    t_bos();
    t_frame_fcs();
    t_frame_nofcs();
    t_idle();
    t_select();
    t_overlap();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R1-watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule